// File: doc/BRIEF.md
# Scatter-Gather Region Descriptor Walker

This block serves one bus-master disk DMA channel. Software places a table of 8-byte region descriptors in host memory and hands its base address to the walker with a start pulse. The walker then serves transfer calls. Each call names a number of bytes and a direction. The walker reads descriptors on demand through a descriptor read port. It keeps the current region's address and its remaining length, and it issues transfer chunks on a chunk port. Each chunk covers as much of the call as the current region still allows. A region that a call leaves half used is carried into the next call, so several calls can share one region.

A descriptor is two little-endian 32-bit words, delivered as one 64-bit value. Bits 31:0 hold the region base address. Bits 47:32 hold the byte count. Bit 63 marks the final entry of the table. The walk ends when the final entry has been used up, or when the table pointer has moved a full window (4096 bytes by default) past the base. If the call still has bytes left at that point, the walker raises an exhausted flag and ends the call early. In both cases it pulses a done strobe and reports the bytes it moved for that call.

The controller has five states. `ST_IDLE` waits for a call. `ST_DECIDE` picks the next action. `ST_FETCH` holds a descriptor read until it is acknowledged. `ST_ISSUE` holds a chunk until it is acknowledged. `ST_FINISH` is the one-cycle done state. The transitions are:

- `ST_IDLE` to `ST_DECIDE` when a call is accepted.
- `ST_DECIDE` to `ST_FINISH` when nothing is pending or when the table is used up.
- `ST_DECIDE` to `ST_ISSUE` when the region has bytes left.
- `ST_DECIDE` to `ST_FETCH` when the region is empty and a fetch is allowed.
- `ST_FETCH` to `ST_DECIDE` on descriptor acknowledge.
- `ST_ISSUE` to `ST_DECIDE` on chunk acknowledge.
- `ST_FINISH` to `ST_IDLE` always.

A start pulse in any state sends the controller to `ST_IDLE`.

Top module: `prd_walker`

## Requirements
- R1: After reset, `busy`, `call_done`, `dsc_req`, `chk_valid` and `exhausted` are 0, and `bytes_done` is 0.
- R2: The first descriptor read after a start uses address `tbl_base`. Each later read uses the previous read address plus 8.
- R3: Descriptor decode works as follows. Bits 31:0 give the region address. Bits 47:32 give the byte count, with bit 32 treated as 0, and a count of 0 means 65536 bytes. Bit 63 set marks the last entry.
- R4: Each chunk has length min(bytes still pending in the call, bytes left in the region), and that length is never 0. `chk_addr` is the current region address. `chk_addr` and `chk_len` stay stable until `chk_ack`.
- R5: After each acknowledged chunk, the region address grows by the chunk length and the region's remaining bytes shrink by it. A partly used region carries over into the next call.
- R6: A descriptor is read only when the current region has no bytes left and the call still has bytes pending. A descriptor read and a chunk are never requested in the same cycle.
- R7: Once the last-marked entry is used up, no further descriptor is read. If bytes are still pending, `exhausted` is 1 when the call ends.
- R8: No descriptor is read once the table pointer minus the base is at least `WIN_BYTES`. If bytes are still pending, `exhausted` is 1 when the call ends.
- R9: A start pulse loads the base, sets the table pointer to it, and clears the last-entry mark, the region address, the region length and `exhausted`.
- R10: `call_done` pulses for one cycle when a call ends, after which `busy` is 0. At that point `bytes_done` equals the bytes moved in that call. `chk_dir` equals the `call_dir` value latched when the call was accepted.
- R11: A call of 0 bytes ends with `call_done` two cycles after acceptance, with no descriptor read and no chunk.
- R12: `call_go` is ignored while `busy` is 1. The running call's byte count is unchanged, and no further call starts after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load table base and clear walk state |
| tbl_base | input | ADDR_W | Descriptor table base address |
| call_go | input | 1 | Begin a transfer call (taken only when idle) |
| call_bytes | input | CNT_W | Bytes requested by the call |
| call_dir | input | 1 | Direction of the call, passed to chunks |
| busy | output | 1 | A call is in progress |
| call_done | output | 1 | One-cycle pulse at the end of a call |
| exhausted | output | 1 | The last call ended with bytes still pending |
| bytes_done | output | CNT_W | Bytes moved by the current or last call |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | ADDR_W | Descriptor read address |
| dsc_ack | input | 1 | Descriptor read completes; data valid |
| dsc_data | input | 64 | Descriptor contents |
| chk_valid | output | 1 | Chunk request valid |
| chk_addr | output | ADDR_W | Chunk start address |
| chk_len | output | LEN_W | Chunk length in bytes |
| chk_dir | output | 1 | Chunk direction |
| chk_ack | input | 1 | Chunk transfer complete |

## Verification
The hardest case to reach is the window limit (R8). It needs a table with no last-marked entry and a call large enough to consume 512 descriptors. The bench builds the table as a function of the fetch address, using 2-byte regions without a last mark. It then issues one call larger than 512 such regions can supply, and a second call to confirm the walker stays exhausted. Regions that carry over between calls are reached by chains of short calls against a fixed table. The 65536-byte encoding is reached by a descriptor whose count field is zero.

// File: rtl/prd_pkg.sv
package prd_pkg;

    localparam int DESC_W = 64;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_FETCH,
        ST_ISSUE,
        ST_FINISH
    } walk_st_t;

endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17
) (
    input  logic [prd_pkg::DESC_W-1:0] desc,
    output logic [ADDR_W-1:0]          rgn_addr,
    output logic [LEN_W-1:0]           rgn_len,
    output logic                       rgn_last
);
    localparam int CNT_FLD_W = LEN_W - 1;

    logic [CNT_FLD_W-1:0] raw_cnt;
    logic                 unused_rsv;

    always_comb begin
        rgn_addr = ADDR_W'(desc[31:0]);
        raw_cnt  = desc[32 +: CNT_FLD_W] & ~CNT_FLD_W'(1);
        if (raw_cnt == '0) begin
            rgn_len = LEN_W'(1) << CNT_FLD_W;
        end else begin
            rgn_len = {1'b0, raw_cnt};
        end
        rgn_last = desc[63];
    end

    assign unused_rsv = ^desc[62:32 + CNT_FLD_W];

endmodule

// File: rtl/prd_chunk_sizer.sv
module prd_chunk_sizer #(
    parameter int CNT_W = 24,
    parameter int LEN_W = 17
) (
    input  logic [CNT_W-1:0] pend,
    input  logic [LEN_W-1:0] rem,
    output logic [LEN_W-1:0] chunk
);
    generate
        if (CNT_W > LEN_W) begin : g_wide
            logic pend_fits;
            assign pend_fits = (pend[CNT_W-1:LEN_W] == '0);
            assign chunk = (pend_fits && (pend[LEN_W-1:0] < rem)) ? pend[LEN_W-1:0] : rem;
        end else begin : g_narrow
            logic [LEN_W-1:0] pend_ext;
            assign pend_ext = LEN_W'(pend);
            assign chunk = (pend_ext < rem) ? pend_ext : rem;
        end
    endgenerate

endmodule

// File: rtl/prd_walker.sv
module prd_walker #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 24,
    parameter int LEN_W     = 17,
    parameter int WIN_BYTES = 4096
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          tbl_base,
    input  logic                       call_go,
    input  logic [CNT_W-1:0]           call_bytes,
    input  logic                       call_dir,
    output logic                       busy,
    output logic                       call_done,
    output logic                       exhausted,
    output logic [CNT_W-1:0]           bytes_done,
    output logic                       dsc_req,
    output logic [ADDR_W-1:0]          dsc_addr,
    input  logic                       dsc_ack,
    input  logic [prd_pkg::DESC_W-1:0] dsc_data,
    output logic                       chk_valid,
    output logic [ADDR_W-1:0]          chk_addr,
    output logic [LEN_W-1:0]           chk_len,
    output logic                       chk_dir,
    input  logic                       chk_ack
);
    import prd_pkg::*;

    localparam logic [ADDR_W-1:0] WIN_LIM  = ADDR_W'(WIN_BYTES);
    localparam logic [ADDR_W-1:0] DESC_STP = ADDR_W'(DESC_W / 8);

    walk_st_t          st, st_nx;
    logic [ADDR_W-1:0] base_q, ptr_q, raddr_q;
    logic [LEN_W-1:0]  rem_q;
    logic              last_q, dir_q, exh_q;
    logic [CNT_W-1:0]  pend_q, bytes_q;

    logic [ADDR_W-1:0] dec_addr;
    logic [LEN_W-1:0]  dec_len;
    logic              dec_last;
    logic [LEN_W-1:0]  cur_chunk;
    logic              win_hit, can_fetch;

    prd_desc_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
        .desc     (dsc_data),
        .rgn_addr (dec_addr),
        .rgn_len  (dec_len),
        .rgn_last (dec_last)
    );

    prd_chunk_sizer #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_size (
        .pend  (pend_q),
        .rem   (rem_q),
        .chunk (cur_chunk)
    );

    assign win_hit   = (ptr_q - base_q) >= WIN_LIM;
    assign can_fetch = !last_q && !win_hit;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (call_go) st_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (pend_q == '0)        st_nx = ST_FINISH;
                else if (rem_q != '0)    st_nx = ST_ISSUE;
                else if (can_fetch)      st_nx = ST_FETCH;
                else                     st_nx = ST_FINISH;
            end
            ST_FETCH:  if (dsc_ack) st_nx = ST_DECIDE;
            ST_ISSUE:  if (chk_ack) st_nx = ST_DECIDE;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st <= ST_IDLE;
        else if (start) st <= ST_IDLE;
        else            st <= st_nx;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            ptr_q   <= '0;
            raddr_q <= '0;
            rem_q   <= '0;
            last_q  <= 1'b0;
            dir_q   <= 1'b0;
            exh_q   <= 1'b0;
            pend_q  <= '0;
            bytes_q <= '0;
        end else if (start) begin
            base_q  <= tbl_base;
            ptr_q   <= tbl_base;
            raddr_q <= '0;
            rem_q   <= '0;
            last_q  <= 1'b0;
            exh_q   <= 1'b0;
            pend_q  <= '0;
            bytes_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (call_go) begin
                    pend_q  <= call_bytes;
                    dir_q   <= call_dir;
                    bytes_q <= '0;
                    exh_q   <= 1'b0;
                end
                ST_DECIDE: if (pend_q != '0 && rem_q == '0 && !can_fetch) begin
                    exh_q <= 1'b1;
                end
                ST_FETCH: if (dsc_ack) begin
                    raddr_q <= dec_addr;
                    rem_q   <= dec_len;
                    last_q  <= dec_last;
                    ptr_q   <= ptr_q + DESC_STP;
                end
                ST_ISSUE: if (chk_ack) begin
                    raddr_q <= raddr_q + ADDR_W'(cur_chunk);
                    rem_q   <= rem_q - cur_chunk;
                    pend_q  <= pend_q - CNT_W'(cur_chunk);
                    bytes_q <= bytes_q + CNT_W'(cur_chunk);
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy       = (st != ST_IDLE);
        call_done  = (st == ST_FINISH);
        dsc_req    = (st == ST_FETCH);
        dsc_addr   = ptr_q;
        chk_valid  = (st == ST_ISSUE);
        chk_addr   = raddr_q;
        chk_len    = cur_chunk;
        chk_dir    = dir_q;
        exhausted  = exh_q;
        bytes_done = bytes_q;
    end

endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int LEN_W  = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] tbl_base,
    input logic              call_go,
    input logic [CNT_W-1:0]  call_bytes,
    input logic              busy,
    input logic              call_done,
    input logic              dsc_req,
    input logic [ADDR_W-1:0] dsc_addr,
    input logic              dsc_ack,
    input logic              chk_valid,
    input logic [ADDR_W-1:0] chk_addr,
    input logic [LEN_W-1:0]  chk_len,
    input logic              chk_ack
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(1) << (LEN_W - 1);

    logic [ADDR_W-1:0] nxt_fetch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                nxt_fetch <= '0;
        else if (start)            nxt_fetch <= tbl_base;
        else if (dsc_req && dsc_ack) nxt_fetch <= dsc_addr + ADDR_W'(8);
    end

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_req |-> dsc_addr == nxt_fetch); // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsc_req && chk_valid)); // R6
    AST_CHUNK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> (chk_len != '0) && (chk_len <= LEN_MAX)); // R4
    AST_CHUNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !chk_ack && !start) |=> chk_valid && $stable(chk_addr) && $stable(chk_len)); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        call_done |=> !busy); // R10
    AST_ZERO_CALL: assert property (@(posedge clk) disable iff (!rst_n || start)
        (call_go && !busy && call_bytes == '0) |=> ##1 call_done); // R11
    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || start)
        (call_go && busy && !call_done) |=> busy); // R12

endmodule

bind prd_walker prd_walker_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tbl_base   (tbl_base),
    .call_go    (call_go),
    .call_bytes (call_bytes),
    .busy       (busy),
    .call_done  (call_done),
    .dsc_req    (dsc_req),
    .dsc_addr   (dsc_addr),
    .dsc_ack    (dsc_ack),
    .chk_valid  (chk_valid),
    .chk_addr   (chk_addr),
    .chk_len    (chk_len),
    .chk_ack    (chk_ack)
);

// File: tb/sim_prd_walker.sv
`timescale 1ns/1ps
module sim_prd_walker;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 24;
    localparam int LEN_W  = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] tbl_base = '0;
    logic              call_go = 1'b0;
    logic [CNT_W-1:0]  call_bytes = '0;
    logic              call_dir = 1'b0;
    logic              busy, call_done, exhausted;
    logic [CNT_W-1:0]  bytes_done;
    logic              dsc_req;
    logic [ADDR_W-1:0] dsc_addr;
    logic              dsc_ack = 1'b0;
    logic [63:0]       dsc_data = '0;
    logic              chk_valid;
    logic [ADDR_W-1:0] chk_addr;
    logic [LEN_W-1:0]  chk_len;
    logic              chk_dir;
    logic              chk_ack = 1'b0;

    prd_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .WIN_BYTES(4096)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
        .call_go(call_go), .call_bytes(call_bytes), .call_dir(call_dir),
        .busy(busy), .call_done(call_done), .exhausted(exhausted), .bytes_done(bytes_done),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack), .dsc_data(dsc_data),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_len(chk_len), .chk_dir(chk_dir),
        .chk_ack(chk_ack)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // table configuration
    int          g_mode = 0;
    int          g_last_idx = -1;
    logic [31:0] g_base = '0;

    // reference walk state
    logic [31:0] m_ptr = '0;
    logic [31:0] m_raddr = '0;
    int          m_rem = 0;
    bit          m_last = 1'b0;
    int          m_pend = 0;
    int          m_call = 0;
    bit          m_dir = 1'b0;
    int          m_nf = 0;
    int          chk_lat = 0;
    int          lat_cnt = 0;
    int          n_chunks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // behavioural descriptor table: entry contents are a function of the index
    function automatic logic [63:0] mem_desc(input logic [31:0] a);
        int          idx;
        logic [15:0] sz;
        logic [31:0] ra;
        bit          lst;
        idx = int'((a - g_base) >> 3);
        ra  = 32'h4000_0000 + 32'(idx) * 32'h0001_0000 + 32'(idx) * 32'd2;
        case (g_mode)
            0:       sz = 16'(idx * 6 + 4);
            1:       sz = (idx == 0) ? 16'h0000 : 16'(idx * 2 + 1);
            2:       sz = 16'(idx * 4 + 3);
            3:       sz = 16'd2;
            default: sz = 16'd8;
        endcase
        lst = (g_last_idx >= 0) && (idx == g_last_idx);
        return {lst, 15'h0, sz, ra};
    endfunction

    // R3 R6 R7 R8: reference fetch rule
    task automatic m_fill();
        logic [63:0] d;
        logic [15:0] sz;
        while (m_pend != 0 && m_rem == 0 && !m_last && (m_ptr - g_base) < 32'd4096) begin
            d       = mem_desc(m_ptr);
            m_raddr = d[31:0];
            sz      = d[47:32] & 16'hFFFE;
            m_rem   = (sz == 16'h0) ? 65536 : int'(sz);
            m_last  = d[63];
            m_ptr   = m_ptr + 32'd8;
        end
    endtask

    // memory-side responder
    always @(negedge clk) begin
        if (dsc_req) begin
            check(dsc_addr == g_base + 32'(m_nf * 8), "R2", "descriptor address",
                  longint'(dsc_addr), longint'(g_base + 32'(m_nf * 8)));
            m_nf++;
            dsc_data = mem_desc(dsc_addr);
            dsc_ack  = 1'b1;
        end else begin
            dsc_ack = 1'b0;
        end
        if (chk_valid) begin
            if (lat_cnt >= chk_lat) begin
                int exp_len;
                lat_cnt = 0;
                chk_ack = 1'b1;
                m_fill();
                exp_len = (m_pend < m_rem) ? m_pend : m_rem;
                check(chk_len == LEN_W'(exp_len), "R4", "chunk length",
                      longint'(chk_len), longint'(exp_len));
                check(chk_addr == m_raddr, "R5", "chunk address",
                      longint'(chk_addr), longint'(m_raddr));
                check(chk_dir == m_dir, "R10", "chunk direction",
                      longint'(chk_dir), longint'(m_dir));
                m_raddr = m_raddr + 32'(exp_len);
                m_rem   = m_rem - exp_len;
                m_pend  = m_pend - exp_len;
                n_chunks++;
            end else begin
                lat_cnt++;
                chk_ack = 1'b0;
            end
        end else begin
            chk_ack = 1'b0;
        end
    end

    task automatic do_start(input logic [31:0] b);
        @(negedge clk);
        start    = 1'b1;
        tbl_base = b;
        g_base   = b;
        m_ptr    = b;
        m_raddr  = '0;
        m_rem    = 0;
        m_last   = 1'b0;
        m_nf     = 0;
        @(negedge clk);
        start = 1'b0;
        check(exhausted == 1'b0, "R9", "exhausted after start", longint'(exhausted), 0);
    endtask

    task automatic do_call(input int nb, input bit dir, input bit inject);
        bit seen;
        int it;
        @(negedge clk);
        call_go    = 1'b1;
        call_bytes = CNT_W'(nb);
        call_dir   = dir;
        m_pend     = nb;
        m_call     = nb;
        m_dir      = dir;
        n_chunks   = 0;
        @(negedge clk);
        call_go = 1'b0;
        seen = 1'b0;
        it   = 0;
        while (!seen && it < 20000) begin
            @(negedge clk);
            it++;
            if (inject && it == 2) begin
                check(busy == 1'b1, "R12", "busy during call", longint'(busy), 1);
                call_go    = 1'b1;
                call_bytes = CNT_W'(999);
            end else if (inject && it == 3) begin
                call_go = 1'b0;
            end
            if (call_done) seen = 1'b1;
        end
        call_go = 1'b0;
        check(seen, "R10", "call_done seen", longint'(seen), 1);
        m_fill();
        check(bytes_done == CNT_W'(m_call - m_pend), "R10", "bytes_done",
              longint'(bytes_done), longint'(m_call - m_pend));
        check(exhausted == (m_pend != 0), "R7", "exhausted at end",
              longint'(exhausted), longint'(m_pend != 0));
        check(g_base + 32'(m_nf * 8) == m_ptr, "R6", "descriptor read count",
              longint'(m_nf), longint'((m_ptr - g_base) >> 3));
        @(negedge clk);
        check(busy == 1'b0, "R10", "idle after done", longint'(busy), 0);
        if (inject) begin
            repeat (4) @(negedge clk);
            check(busy == 1'b0, "R12", "ignored go started nothing", longint'(busy), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", longint'(busy), 0);
        check(call_done == 1'b0, "R1", "call_done", longint'(call_done), 0);
        check(dsc_req == 1'b0, "R1", "dsc_req", longint'(dsc_req), 0);
        check(chk_valid == 1'b0, "R1", "chk_valid", longint'(chk_valid), 0);
        check(exhausted == 1'b0, "R1", "exhausted", longint'(exhausted), 0);
        check(bytes_done == '0, "R1", "bytes_done", longint'(bytes_done), 0);

        // R4 R5: regions 4,10,16,22 bytes, last at entry 3; calls of every size
        g_mode = 0; g_last_idx = 3; chk_lat = 0;
        for (int n = 0; n <= 60; n++) begin
            do_start(32'h0000_8000 + 32'(n * 64));
            do_call(n, n[0], 1'b0);
        end

        // R5 carry-over: chain of short calls through one table
        do_start(32'h0012_3400);
        for (int k = 0; k < 9; k++) do_call(7, k[0], 1'b0);

        // R11 zero-byte call with a region partly used
        do_start(32'h0000_2000);
        do_call(3, 1'b0, 1'b0);
        do_call(0, 1'b1, 1'b0);
        check(n_chunks == 0, "R11", "no chunk on empty call", longint'(n_chunks), 0);

        // R12 go while busy, with slow chunk acknowledge
        chk_lat = 3;
        do_start(32'h0000_3000);
        do_call(40, 1'b1, 1'b1);

        // R9 restart after an exhausted walk
        chk_lat = 0;
        do_start(32'h0000_4000);
        do_call(100, 1'b0, 1'b0);
        do_start(32'h0000_4000);
        do_call(12, 1'b0, 1'b0);

        // R3 zero count means 65536, odd counts lose bit 0
        g_mode = 1; g_last_idx = 4; chk_lat = 2;
        do_start(32'h0001_0000);
        do_call(70000, 1'b1, 1'b0);
        g_mode = 2; g_last_idx = 2; chk_lat = 1;
        do_start(32'h0002_0000);
        do_call(15, 1'b0, 1'b0);
        do_call(10, 1'b1, 1'b0);

        // R8 window limit: 2-byte regions, no last mark
        g_mode = 3; g_last_idx = -1; chk_lat = 0;
        do_start(32'h0010_0000);
        do_call(2000, 1'b0, 1'b0);
        check(bytes_done == CNT_W'(1024), "R8", "bytes within window",
              longint'(bytes_done), 1024);
        do_call(5, 1'b1, 1'b0);

        summary();
        $finish;
    end

endmodule